// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block owns the program counter, stack pointer and status byte of an 8-bit processor during the cycles in which control changes hands. These are reset, a non-maskable interrupt, a maskable interrupt, a software break, a return from interrupt and a return from subroutine. Every cycle in which the block is idle counts as an instruction boundary. In such a cycle it samples the request lines and the instruction strobes, chooses one of them, and then runs a fixed micro-sequence. The sequence pushes onto or pops from the stack page through a byte-wide memory port, or fetches a new PC from a vector. The memory read data is combinational: it is valid in the same cycle as the address.

The execution core keeps running normal instructions itself. It hands its updated PC and status byte back through two load ports, which take effect only in idle cycles. A running cycle counter adds the cost of each sequence, so the core can keep its timing budget.

Top module: `irq_entry_seq`

## Requirements
- R1: While reset is asserted, SP is 0xFF, the status byte is 0x22 (bit 1 zero-result and bit 5 always-one set) and the cycle count is 0. After release the block is busy for two cycles. It reads 0xFFFC and then 0xFFFD and loads PC with {high, low}. These two cycles do not add to the cycle count.
- R2: In an idle cycle the block picks exactly one of these, from highest to lowest priority:
  - a pending non-maskable request;
  - `irq_req` high, with status bit 2 (I) clear or `cli_go` high;
  - `brk_go`;
  - `rti_go`;
  - `rts_go`;
  - `cli_go` alone.
  Every lower-priority strobe and both load ports are ignored in that cycle.
- R3: An entry pushes the PC high byte, then the PC low byte, then the status byte. Each push writes address 0x0100+SP and then decrements SP. `mem_we` is high only in push cycles.
- R4: A hardware entry pushes the status byte with bit 4 (B) clear. After that push, bit 3 (D) is clear. A maskable entry also sets I, and a non-maskable entry leaves I unchanged.
- R5: A break first adds 1 to PC. It then pushes that PC and the status byte with B set. After the push I is set and D is clear, and PC is loaded from the maskable vector.
- R6: Entries and breaks keep `busy` high for 7 cycles: two internal cycles, three push cycles, then two vector reads. Returns from interrupt use three internal cycles, and returns from subroutine use four, followed by their pops; both take 6 cycles. `cyc_cnt` rises by one in each such busy cycle and holds its value while idle.
- R7: Vectors are fetched low byte first. The non-maskable vector is at 0xFFFA/0xFFFB, and the maskable and break vector is at 0xFFFE/0xFFFF.
- R8: A return from interrupt increments SP before each read. It pops the status byte and forces bit 5 to 1, then pops PC low, then PC high.
- R9: A return from subroutine pops PC low and then PC high with pre-increment, and loads PC with the popped value plus 1.
- R10: If `cli_go` arrives while `irq_req` is high, I is cleared and the maskable entry starts in that same cycle. The pushed status byte shows I clear.
- R11: A rising edge of `nmi_req` is remembered while the block is busy and is taken in the next idle cycle. If the line stays high, it does not raise a second request.
- R12: `pc_load` and `p_load` write PC and the status byte only in an idle cycle in which no sequence starts and `cli_go` is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_req | input | 1 | Non-maskable request; its rising edge is latched |
| irq_req | input | 1 | Maskable request, level sensitive |
| brk_go | input | 1 | Start a software break |
| rti_go | input | 1 | Start a return from interrupt |
| rts_go | input | 1 | Start a return from subroutine |
| cli_go | input | 1 | Interrupt-enable instruction: clear I |
| pc_load | input | 1 | Load PC from pc_in when idle |
| pc_in | input | 16 | PC value from the core |
| p_load | input | 1 | Load status from p_in when idle |
| p_in | input | 8 | Status value from the core |
| mem_we | output | 1 | Memory write strobe (stack push) |
| mem_re | output | 1 | Memory read strobe (pop or vector) |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Byte being pushed |
| mem_rdata | input | 8 | Read data, valid in the same cycle |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| p | output | 8 | Status byte |
| busy | output | 1 | A sequence is running |
| cyc_cnt | output | 16 | Accumulated sequence cycles |

## Verification
The properties assume that the memory answers reads in the same cycle and that the core issues loads and strobes only when it sees `busy` low. A load presented while busy is tolerated but has no effect. The stimulus holds strobes for a single idle cycle each. It raises `nmi_req` both from idle and in the middle of a sequence, and it stacks conflicting strobes into one cycle deliberately. A behavioural model that keeps a queue of expected bus steps is compared with every output on every clock.

// File: rtl/ies_pkg.sv
package ies_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int PH_W   = 3;

  localparam logic [7:0] STACK_PAGE = 8'h01;

  localparam int unsigned FLAG_Z = 1;
  localparam int unsigned FLAG_I = 2;
  localparam int unsigned FLAG_D = 3;
  localparam int unsigned FLAG_B = 4;
  localparam int unsigned FLAG_R = 5;

  localparam logic [DATA_W-1:0] STATUS_AT_RESET = DATA_W'((1 << FLAG_Z) | (1 << FLAG_R));

  localparam logic [ADDR_W-1:0] VEC_NMI = 16'hFFFA;
  localparam logic [ADDR_W-1:0] VEC_RST = 16'hFFFC;
  localparam logic [ADDR_W-1:0] VEC_IRQ = 16'hFFFE;

  typedef enum logic [2:0] {K_RST, K_NMI, K_IRQ, K_BRK, K_RTI, K_RTS} seq_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WAIT, ST_PSH_H, ST_PSH_L, ST_PSH_P,
    ST_VEC_L, ST_VEC_H, ST_POP_P, ST_POP_L, ST_POP_H
  } step_e;

  function automatic logic [PH_W-1:0] seq_len(seq_kind_e k);
    case (k)
      K_RST:        return PH_W'(2);
      K_RTI, K_RTS: return PH_W'(6);
      default:      return PH_W'(7);
    endcase
  endfunction

  function automatic step_e step_of(seq_kind_e k, logic [PH_W-1:0] ph);
    step_e s;
    s = ST_WAIT;
    case (k)
      K_RST: s = (ph == '0) ? ST_VEC_L : ST_VEC_H;
      K_NMI, K_IRQ, K_BRK:
        case (ph)
          3'd2: s = ST_PSH_H;
          3'd3: s = ST_PSH_L;
          3'd4: s = ST_PSH_P;
          3'd5: s = ST_VEC_L;
          3'd6: s = ST_VEC_H;
          default: s = ST_WAIT;
        endcase
      K_RTI:
        case (ph)
          3'd3: s = ST_POP_P;
          3'd4: s = ST_POP_L;
          3'd5: s = ST_POP_H;
          default: s = ST_WAIT;
        endcase
      K_RTS:
        case (ph)
          3'd4: s = ST_POP_L;
          3'd5: s = ST_POP_H;
          default: s = ST_WAIT;
        endcase
      default: s = ST_WAIT;
    endcase
    return s;
  endfunction

  function automatic logic [ADDR_W-1:0] vec_base(seq_kind_e k);
    case (k)
      K_NMI:   return VEC_NMI;
      K_RST:   return VEC_RST;
      default: return VEC_IRQ;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] pushed_status(seq_kind_e k, logic [DATA_W-1:0] st);
    logic [DATA_W-1:0] r;
    r = st;
    r[FLAG_B] = (k == K_BRK);
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] entry_status(seq_kind_e k, logic [DATA_W-1:0] st);
    logic [DATA_W-1:0] r;
    r = st;
    r[FLAG_D] = 1'b0;
    if (k == K_IRQ || k == K_BRK) r[FLAG_I] = 1'b1;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] popped_status(logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] r;
    r = b;
    r[FLAG_R] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/ies_arbiter.sv
module ies_arbiter
  import ies_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      idle,
  input  logic      nmi_req,
  input  logic      irq_req,
  input  logic      i_flag,
  input  logic      brk_go,
  input  logic      rti_go,
  input  logic      rts_go,
  input  logic      cli_go,
  output logic      start,
  output seq_kind_e start_kind,
  output logic      cli_take,
  output logic      load_ok
);
  logic nmi_q, nmi_pend, nmi_edge, nmi_hit, irq_ok;

  assign nmi_edge = nmi_req & ~nmi_q;
  assign nmi_hit  = nmi_pend | nmi_edge;
  assign irq_ok   = irq_req & (~i_flag | cli_go);

  always_comb begin
    start      = 1'b0;
    start_kind = K_NMI;
    cli_take   = 1'b0;
    if (idle) begin
      if (nmi_hit) begin
        start = 1'b1;
        start_kind = K_NMI;
      end else if (irq_ok) begin
        start = 1'b1;
        start_kind = K_IRQ;
        cli_take = cli_go;
      end else if (brk_go) begin
        start = 1'b1;
        start_kind = K_BRK;
      end else if (rti_go) begin
        start = 1'b1;
        start_kind = K_RTI;
      end else if (rts_go) begin
        start = 1'b1;
        start_kind = K_RTS;
      end else if (cli_go) begin
        cli_take = 1'b1;
      end
    end
  end

  assign load_ok = idle & ~start & ~cli_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q    <= nmi_req;
      nmi_pend <= nmi_hit & ~(start && start_kind == K_NMI);
    end
  end
endmodule

// File: rtl/ies_sequencer.sv
module ies_sequencer
  import ies_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  seq_kind_e        start_kind,
  output logic             active,
  output seq_kind_e        kind,
  output step_e            step,
  output logic [CNT_W-1:0] cyc_cnt
);
  logic [PH_W-1:0] ph;
  logic            last;

  assign last = (ph == seq_len(kind) - PH_W'(1));
  assign step = active ? step_of(kind, ph) : ST_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b1;
      kind    <= K_RST;
      ph      <= '0;
      cyc_cnt <= '0;
    end else if (active) begin
      if (kind != K_RST) cyc_cnt <= cyc_cnt + CNT_W'(1);
      if (last) begin
        active <= 1'b0;
        ph     <= '0;
      end else begin
        ph <= ph + PH_W'(1);
      end
    end else if (start) begin
      active <= 1'b1;
      kind   <= start_kind;
      ph     <= '0;
    end
  end
endmodule

// File: rtl/ies_bus.sv
module ies_bus
  import ies_pkg::*;
(
  input  step_e              step,
  input  seq_kind_e          kind,
  input  logic [ADDR_W-1:0]  pc,
  input  logic [7:0]         sp,
  input  logic [DATA_W-1:0]  p,
  output logic               mem_we,
  output logic               mem_re,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata
);
  logic [ADDR_W-1:0] push_addr, pop_addr, vec_addr;

  assign push_addr = {STACK_PAGE, sp};
  assign pop_addr  = {STACK_PAGE, sp + 8'd1};
  assign vec_addr  = vec_base(kind);

  always_comb begin
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (step)
      ST_PSH_H: begin mem_we = 1'b1; mem_addr = push_addr; mem_wdata = pc[15:8]; end
      ST_PSH_L: begin mem_we = 1'b1; mem_addr = push_addr; mem_wdata = pc[7:0]; end
      ST_PSH_P: begin mem_we = 1'b1; mem_addr = push_addr; mem_wdata = pushed_status(kind, p); end
      ST_VEC_L: begin mem_re = 1'b1; mem_addr = vec_addr; end
      ST_VEC_H: begin mem_re = 1'b1; mem_addr = vec_addr + ADDR_W'(1); end
      ST_POP_P, ST_POP_L, ST_POP_H: begin mem_re = 1'b1; mem_addr = pop_addr; end
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import ies_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_req,
  input  logic              irq_req,
  input  logic              brk_go,
  input  logic              rti_go,
  input  logic              rts_go,
  input  logic              cli_go,
  input  logic              pc_load,
  input  logic [15:0]       pc_in,
  input  logic              p_load,
  input  logic [7:0]        p_in,
  output logic              mem_we,
  output logic              mem_re,
  output logic [15:0]       mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic [15:0]       pc,
  output logic [7:0]        sp,
  output logic [7:0]        p,
  output logic              busy,
  output logic [CNT_W-1:0]  cyc_cnt
);
  logic      active, start, cli_take, load_ok;
  seq_kind_e start_kind, kind;
  step_e     step;
  logic [7:0] lo_byte;

  logic vec_fetch, push_stat, pop_stat;
  assign vec_fetch = (step == ST_VEC_L) || (step == ST_VEC_H);
  assign push_stat = (step == ST_PSH_P);
  assign pop_stat  = (step == ST_POP_P);
  assign busy      = active;

  ies_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .idle(~active),
    .nmi_req(nmi_req), .irq_req(irq_req), .i_flag(p[FLAG_I]),
    .brk_go(brk_go), .rti_go(rti_go), .rts_go(rts_go), .cli_go(cli_go),
    .start(start), .start_kind(start_kind), .cli_take(cli_take), .load_ok(load_ok)
  );

  ies_sequencer #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_kind(start_kind),
    .active(active), .kind(kind), .step(step), .cyc_cnt(cyc_cnt)
  );

  ies_bus u_bus (
    .step(step), .kind(kind), .pc(pc), .sp(sp), .p(p),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc      <= '0;
      sp      <= 8'hFF;
      p       <= STATUS_AT_RESET;
      lo_byte <= '0;
    end else begin
      if (load_ok) begin
        if (pc_load) pc <= pc_in;
        if (p_load)  p  <= p_in;
      end
      if (start && start_kind == K_BRK) pc <= pc + 16'd1;
      if (cli_take) p[FLAG_I] <= 1'b0;
      case (step)
        ST_PSH_H, ST_PSH_L: sp <= sp - 8'd1;
        ST_PSH_P: begin
          sp <= sp - 8'd1;
          p  <= entry_status(kind, p);
        end
        ST_VEC_L: lo_byte <= mem_rdata;
        ST_VEC_H: pc <= {mem_rdata, lo_byte};
        ST_POP_P: begin
          sp <= sp + 8'd1;
          p  <= popped_status(mem_rdata);
        end
        ST_POP_L: begin
          sp      <= sp + 8'd1;
          lo_byte <= mem_rdata;
        end
        ST_POP_H: begin
          sp <= sp + 8'd1;
          pc <= {mem_rdata, lo_byte} + ((kind == K_RTS) ? 16'd1 : 16'd0);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ies_chk.sv
module ies_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_we,
  input logic             mem_re,
  input logic [15:0]      mem_addr,
  input logic [7:0]       sp,
  input logic [7:0]       p,
  input logic             busy,
  input logic [CNT_W-1:0] cyc_cnt,
  input logic             vec_fetch,
  input logic             push_stat,
  input logic             pop_stat
);
  assert_push_on_stack_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[15:8] == 8'h01);

  assert_sp_falls_per_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp == 8'($past(sp) - 8'd1));

  assert_bus_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  assert_idle_bus_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re));

  assert_cycle_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cyc_cnt == $past(cyc_cnt) || cyc_cnt == CNT_W'($past(cyc_cnt) + 1'b1)));

  assert_cycle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(cyc_cnt));

  assert_vector_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch |-> (mem_addr[15:3] == 13'h1FFF && mem_addr[2:1] != 2'b00));

  assert_entry_clears_d_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push_stat |=> !p[3]);

  assert_return_sets_one_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop_stat |=> p[5]);
endmodule

bind irq_entry_seq ies_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
  .sp(sp), .p(p), .busy(busy), .cyc_cnt(cyc_cnt), .vec_fetch(vec_fetch),
  .push_stat(push_stat), .pop_stat(pop_stat)
);

// File: tb/irq_entry_seq_tb.sv
`timescale 1ns/1ps
module irq_entry_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_req = 0, irq_req = 0, brk_go = 0, rti_go = 0, rts_go = 0, cli_go = 0;
  logic pc_load = 0, p_load = 0;
  logic [15:0] pc_in = '0;
  logic [7:0]  p_in = '0;
  logic mem_we, mem_re, busy;
  logic [15:0] mem_addr, pc, cyc_cnt;
  logic [7:0]  mem_wdata, mem_rdata, sp, p;

  always #2.5 clk = ~clk;

  irq_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .irq_req(irq_req),
    .brk_go(brk_go), .rti_go(rti_go), .rts_go(rts_go), .cli_go(cli_go),
    .pc_load(pc_load), .pc_in(pc_in), .p_load(p_load), .p_in(p_in),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .pc(pc), .sp(sp), .p(p), .busy(busy), .cyc_cnt(cyc_cnt)
  );

  logic [7:0] stk [256];
  logic [7:0] vecm [8];

  always_comb begin
    if (mem_addr[15:8] == 8'h01)       mem_rdata = stk[mem_addr[7:0]];
    else if (mem_addr[15:3] == 13'h1FFF) mem_rdata = vecm[mem_addr[2:0]];
    else                               mem_rdata = 8'h00;
  end

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: queue of expected bus steps
  // 0 internal, 1 push hi, 2 push lo, 3 push status, 4 vec lo, 5 vec hi,
  // 6 pop status, 7 pop lo, 8 pop hi
  int q[$];
  int m_kind;  // 0 reset 1 nmi 2 irq 3 brk 4 rti 5 rts
  logic [15:0] m_pc, m_cyc;
  logic [7:0]  m_sp, m_p, m_tmp;
  bit m_busy, m_npend, m_nprev;

  function automatic logic [15:0] m_vec();
    return (m_kind == 1) ? 16'hFFFA : (m_kind == 0) ? 16'hFFFC : 16'hFFFE;
  endfunction

  task automatic begin_seq(int k);
    m_kind = k;
    m_busy = 1;
    q.delete();
    if (k == 0) q = '{4, 5};
    else if (k <= 3) q = '{0, 0, 1, 2, 3, 4, 5};
    else if (k == 4) q = '{0, 0, 0, 6, 7, 8};
    else q = '{0, 0, 0, 0, 7, 8};
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = 0; m_sp = 8'hFF; m_p = 8'h22; m_cyc = 0; m_tmp = 0;
      m_nprev = 0; m_npend = 0;
      begin_seq(0);
    end else begin
      bit edge_n, hit, taken;
      int s;
      edge_n = nmi_req && !m_nprev;
      if (!m_busy) begin
        hit = m_npend || edge_n;
        taken = 0;
        if (hit) begin begin_seq(1); taken = 1; end
        else if (irq_req && (!m_p[2] || cli_go)) begin
          if (cli_go) m_p[2] = 1'b0;
          begin_seq(2);
        end
        else if (brk_go) begin m_pc = m_pc + 16'd1; begin_seq(3); end
        else if (rti_go) begin_seq(4);
        else if (rts_go) begin_seq(5);
        else if (cli_go) m_p[2] = 1'b0;
        else begin
          if (pc_load) m_pc = pc_in;
          if (p_load) m_p = p_in;
        end
        m_npend = hit && !taken;
      end else begin
        m_npend = m_npend || edge_n;
        s = q.pop_front();
        if (m_kind != 0) m_cyc = m_cyc + 16'd1;
        case (s)
          1, 2: m_sp = m_sp - 8'd1;
          3: begin
            m_sp = m_sp - 8'd1;
            m_p[3] = 1'b0;
            if (m_kind == 2 || m_kind == 3) m_p[2] = 1'b1;
          end
          4: m_tmp = vecm[m_vec() & 16'h7];
          5: m_pc = {vecm[(m_vec() + 16'd1) & 16'h7], m_tmp};
          6: begin m_sp = m_sp + 8'd1; m_p = stk[m_sp] | 8'h20; end
          7: begin m_sp = m_sp + 8'd1; m_tmp = stk[m_sp]; end
          8: begin
            m_sp = m_sp + 8'd1;
            m_pc = {stk[m_sp], m_tmp} + ((m_kind == 5) ? 16'd1 : 16'd0);
          end
          default: ;
        endcase
        if (q.size() == 0) m_busy = 0;
      end
      m_nprev = nmi_req;
    end
  end

  // Per-cycle comparison, then stack memory update from the write port
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int f;
      bit ewe, ere;
      logic [15:0] ea;
      logic [7:0] ed;
      f = m_busy ? q[0] : -1;
      ewe = (f >= 1 && f <= 3);
      ere = (f >= 4 && f <= 8);
      ea = 0; ed = 0;
      case (f)
        1: begin ea = {8'h01, m_sp}; ed = m_pc[15:8]; end
        2: begin ea = {8'h01, m_sp}; ed = m_pc[7:0]; end
        3: begin ea = {8'h01, m_sp}; ed = (m_kind == 3) ? (m_p | 8'h10) : (m_p & 8'hEF); end
        4: ea = m_vec();
        5: ea = m_vec() + 16'd1;
        6, 7, 8: ea = {8'h01, m_sp + 8'd1};
        default: ;
      endcase
      chk("R6", "busy", int'(busy), int'(m_busy));
      chk("R7", "pc", int'(pc), int'(m_pc));
      chk("R3", "sp", int'(sp), int'(m_sp));
      chk("R4", "status", int'(p), int'(m_p));
      chk("R6", "cyc_cnt", int'(cyc_cnt), int'(m_cyc));
      chk("R3", "mem_we", int'(mem_we), int'(ewe));
      chk("R8", "mem_re", int'(mem_re), int'(ere));
      if (ewe || ere) chk("R3", "mem_addr", int'(mem_addr), int'(ea));
      if (ewe) chk("R5", "mem_wdata", int'(mem_wdata), int'(ed));
      if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] = mem_wdata;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_idle();
    while (busy) tick();
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R6 watchdog: actual still running expected finished");
    finish_run();
  end

  initial begin
    logic [7:0] sv;
    for (int i = 0; i < 256; i++) stk[i] = 8'h00;
    vecm[2] = 8'h34; vecm[3] = 8'h12;   // NMI -> 0x1234
    vecm[4] = 8'h00; vecm[5] = 8'h80;   // reset -> 0x8000
    vecm[6] = 8'hBC; vecm[7] = 8'h9A;   // IRQ/BRK -> 0x9ABC
    vecm[0] = 8'h00; vecm[1] = 8'h00;
    repeat (3) tick();
    chk("R1", "sp in reset", int'(sp), 8'hFF);
    chk("R1", "status in reset", int'(p), 8'h22);
    rst_n = 1'b1;
    tick();
    wait_idle();
    chk("R1", "pc after reset", int'(pc), 16'h8000);
    chk("R1", "cycle count after reset", int'(cyc_cnt), 0);

    // R12: loads in an idle cycle
    pc_load = 1; pc_in = 16'hC123; p_load = 1; p_in = 8'h00;
    tick();
    pc_load = 0; p_load = 0;
    chk("R12", "pc loaded", int'(pc), 16'hC123);
    chk("R12", "status loaded", int'(p), 8'h00);

    // R2: NMI beats IRQ in the same cycle
    nmi_req = 1; irq_req = 1;
    tick();
    nmi_req = 0;
    wait_idle();
    chk("R7", "pc from nmi vector", int'(pc), 16'h1234);
    chk("R3", "pushed pc hi", int'(stk[8'hFF]), 8'hC1);
    chk("R3", "pushed pc lo", int'(stk[8'hFE]), 8'h23);
    chk("R4", "nmi pushed status B clear", int'(stk[8'hFD]), 8'h00);
    chk("R4", "nmi leaves I", int'(p[2]), 0);
    chk("R6", "seven cycles per entry", int'(cyc_cnt), 7);
    tick();
    chk("R2", "irq follows nmi", int'(busy), 1);
    wait_idle();
    irq_req = 0;
    chk("R7", "pc from irq vector", int'(pc), 16'h9ABC);
    chk("R4", "irq sets I", int'(p[2]), 1);
    chk("R3", "sp after two entries", int'(sp), 8'hF9);
    chk("R6", "count after two entries", int'(cyc_cnt), 14);

    // R8: two returns from interrupt
    rti_go = 1; tick(); rti_go = 0; wait_idle();
    chk("R8", "rti pc", int'(pc), 16'h1234);
    chk("R8", "rti status bit5 forced", int'(p), 8'h20);
    chk("R6", "rti six cycles", int'(cyc_cnt), 20);
    rti_go = 1; tick(); rti_go = 0; wait_idle();
    chk("R8", "second rti pc", int'(pc), 16'hC123);
    chk("R8", "second rti sp", int'(sp), 8'hFF);

    // R5: software break
    p_load = 1; p_in = 8'h0C; tick(); p_load = 0;
    brk_go = 1; tick(); brk_go = 0; wait_idle();
    chk("R5", "brk pushed pc+1 lo", int'(stk[8'hFE]), 8'h24);
    chk("R5", "brk pushed status B set", int'(stk[8'hFD]), 8'h1C);
    chk("R5", "brk status after", int'(p), 8'h04);
    chk("R5", "brk vector", int'(pc), 16'h9ABC);

    // R9: return from subroutine
    rts_go = 1; tick(); rts_go = 0; wait_idle();
    chk("R9", "rts pc plus one", int'(pc), 16'h241D);
    chk("R9", "rts sp", int'(sp), 8'hFE);

    // R10: masked irq waits, then cli enters at once
    irq_req = 1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R10", "masked irq stays idle", int'(busy), 0);
    end
    cli_go = 1; tick(); cli_go = 0;
    chk("R10", "cli enters irq at once", int'(busy), 1);
    wait_idle();
    irq_req = 0;
    chk("R10", "pushed status shows I clear", int'(stk[8'hFC]), 8'h00);
    chk("R10", "I set after entry", int'(p), 8'h04);

    // R11: NMI edge during a busy sequence, then held high
    brk_go = 1; tick(); brk_go = 0;
    tick(); tick();
    nmi_req = 1;
    wait_idle();
    chk("R11", "brk finished first", int'(pc), 16'h9ABC);
    tick();
    chk("R11", "pending nmi taken", int'(busy), 1);
    wait_idle();
    chk("R11", "nmi vector", int'(pc), 16'h1234);
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R11", "held nmi does not retrigger", int'(busy), 0);
    end
    nmi_req = 0;
    tick();

    // R2 and R12: strobes and loads lose to an NMI; loads while busy ignored
    sv = sp;
    nmi_req = 1; brk_go = 1; pc_load = 1; pc_in = 16'h5555;
    tick();
    brk_go = 0; nmi_req = 0;
    tick();
    pc_load = 0;
    wait_idle();
    chk("R2", "break ignored, pc hi pushed", int'(stk[sv]), 8'h12);
    chk("R2", "break ignored, pc lo pushed", int'(stk[8'(sv - 8'd1)]), 8'h34);
    chk("R12", "load ignored", int'(pc), 16'h1234);
    tick(); tick();
    chk("R2", "dropped break stays dropped", int'(busy), 0);

    finish_run();
  end
endmodule